// File: doc/BRIEF.md
# Buffered Half-Duplex SPI Master

This block is a memory-mapped SPI master built around one shared byte buffer of sixteen entries. Software fills the buffer with the bytes of a command, an address and any payload. It then writes a transfer register that holds two counts. The send count says how many buffer entries to shift out. The total count says how many byte times to clock in all.

During the byte times after the send phase, the block captures the bytes that arrive on the serial input. Each one is written back into the buffer at the index of its byte time. A single transaction is therefore a send phase followed by a read phase. A write-only transaction uses a total equal to the send count.

Software polls a busy bit in the status register to learn when the transaction has ended. It then reads the received bytes out of the buffer. The serial clock runs in mode 0: it idles low, input is sampled on the rising edge, and bytes go out most significant bit first. Its period is set by a divider field in the configuration register.

Top module: `spi_buf_master`

## Requirements
- R1: After reset, the chip select output is high, the serial clock is low, and both the configuration register and the status register read as zero.
- R2: Register access uses 64-bit words, and a word acts only when the low three address bits are zero. Read data appears one clock after the address is presented. The registers are placed as follows:
  - Configuration at byte offset 0x00: bit 0 is the controller enable, bit 1 is the chip-select enable, and bits 15:8 are the divider.
  - Status at 0x08: bit 0 is busy.
  - Transfer at 0x10: bits 4:0 are the send count and bits 12:8 are the total count.
  - Buffer entry i at 0x80 + 8*i: only bits 7:0 are stored, and the upper bits read as zero.
- R3: In a transaction, entries 0 up to the send count minus 1 are shifted out in order, most significant bit first, with the output changing only while the serial clock is low. During byte times at or beyond the send count, the serial output sends zero.
- R4: A byte received during byte time k, where k is at or above the send count and below the total, is stored in buffer entry k. Entries below the send count are not changed.
- R5: When the total equals the send count, no buffer entry is changed by the transaction.
- R6: Busy reads as one from the clock after an accepted transfer write until the trailing half period has ended. It reads zero afterwards.
- R7: The serial clock period is 2*D system clocks, where D is the divider. D = 0x7D is supported, and D = 0 acts as D = 1.
- R8: When chip-select enable is set, the chip select goes low D clocks before the first rising serial clock edge. It stays low through all byte times and goes high D clocks after the last falling edge. When chip-select enable is clear, the chip select stays high for the whole transaction.
- R9: Writing a transfer value whose counts are both zero starts no transaction and leaves busy clear.
- R10: A count above 16 is treated as 16. A total smaller than the send count is treated as equal to the send count.
- R11: A transfer write while busy is ignored: it changes neither the transaction in progress nor the value read back from the transfer register.
- R12: While the controller enable is clear, no transaction starts, the serial clock stays low and the chip select stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the word at reg_addr |
| reg_addr | input | 8 | Byte address of the register word |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, registered, for the word addressed one clock earlier |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Two windows are hard to reach from the ports.

The first is the busy window in which a second transfer write must be dropped. The stimulus reaches it by issuing the second write on the very next bus slot after the first. It then confirms both the clocked-out byte count and the transfer readback.

The second is the read phase. Received bytes are correct only if they land at the index of their byte time. The bench's slave model derives each input bit from the running count of rising edges since the transfer write, so a misplaced or shifted byte shows up as a wrong buffer value. The same model, combined with timestamps of chip-select and clock edges, checks the lead and trail intervals at a small divider and at 0x7D.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TRAIL = 2'd3
    } seq_state_e;

    // Register word indices (byte offset / 8)
    localparam int CFG_WORD      = 0;
    localparam int STS_WORD      = 1;
    localparam int XFER_WORD     = 2;
    localparam int BUF_BASE_WORD = 16;

    // Field positions
    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_CSEN_BIT = 1;
    localparam int CFG_DIV_LSB  = 8;
    localparam int STS_BUSY_BIT = 0;
    localparam int XFER_TX_LSB  = 0;
    localparam int XFER_TOT_LSB = 8;

endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim   = (div == '0) ? DIV_W'(1) : div;
        tick  = run && (cnt_q == lim - DIV_W'(1));
        cnt_d = cnt_q + DIV_W'(1);
        if (!run || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Half-period ticks are spaced by the divider; adjacent ticks only for D<=1
    assert_tick_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div > DIV_W'(1)) |=> (!tick || $changed(div)));

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       shift,
    input  logic       sample,
    input  logic       miso,
    output logic       mosi,
    output logic [7:0] rx_byte
);

    logic [7:0] tx_d, tx_q;
    logic [7:0] rx_d, rx_q;

    always_comb begin
        tx_d = tx_q;
        rx_d = rx_q;
        if (load) begin
            tx_d = load_byte;
        end else if (shift) begin
            tx_d = {tx_q[6:0], 1'b0};
        end
        if (sample) begin
            rx_d = {rx_q[6:0], miso};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            tx_q <= tx_d;
            rx_q <= rx_d;
        end
    end

    assign mosi    = tx_q[7];
    assign rx_byte = rx_q;

    // A new byte load and a bit shift never coincide (R3 bit ordering)
    assert_load_shift_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !shift);

endmodule

// File: rtl/spi_buf_master.sv
module spi_buf_master
    import spi_buf_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int CNT_W       = 5,
    parameter int DIV_W       = 8,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    localparam int IDX_W  = $clog2(NUM_ENTRIES);
    localparam int NUM_W  = IDX_W + 1;
    localparam int WORD_W = ADDR_W - 3;

    typedef struct packed {
        seq_state_e                  st;
        logic                        en;
        logic                        cs_en;
        logic [DIV_W-1:0]            div;
        logic [CNT_W-1:0]            tx_raw;
        logic [CNT_W-1:0]            tot_raw;
        logic [NUM_W-1:0]            ntx;
        logic [NUM_W-1:0]            ntot;
        logic [IDX_W-1:0]            idx;
        logic [3:0]                  bits;
        logic                        sck;
        logic [NUM_ENTRIES-1:0][7:0] mem;
        logic [DATA_W-1:0]           rdata;
    } regs_t;

    function automatic logic [NUM_W-1:0] clamp_cnt(input logic [CNT_W-1:0] c);
        if (int'(c) > NUM_ENTRIES) begin
            return NUM_W'(NUM_ENTRIES);
        end
        return NUM_W'(c);
    endfunction

    regs_t             r_d, r_q;
    logic              tick;
    logic              run;
    logic              shf_load, shf_shift, shf_sample;
    logic [7:0]        shf_byte;
    logic [7:0]        rx_byte;
    logic              mosi_raw;
    logic [WORD_W-1:0] word;
    logic              aligned;
    logic              buf_hit;
    logic [IDX_W-1:0]  ent;
    logic [NUM_W-1:0]  req_tx, req_tot;
    logic [NUM_W-1:0]  nxt;
    logic              xfer_wr;

    assign run = (r_q.st != ST_IDLE);

    spi_sck_gen #(.DIV_W(DIV_W)) u_sck (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (r_q.div),
        .tick  (tick)
    );

    spi_byte_shifter u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (shf_load),
        .load_byte (shf_byte),
        .shift     (shf_shift),
        .sample    (shf_sample),
        .miso      (spi_miso),
        .mosi      (mosi_raw),
        .rx_byte   (rx_byte)
    );

    always_comb begin
        r_d        = r_q;
        shf_load   = 1'b0;
        shf_shift  = 1'b0;
        shf_sample = 1'b0;
        shf_byte   = 8'h00;

        // Address decode
        word    = reg_addr[ADDR_W-1:3];
        aligned = (reg_addr[2:0] == 3'b000);
        buf_hit = aligned && (int'(word) >= BUF_BASE_WORD)
                          && (int'(word) < BUF_BASE_WORD + NUM_ENTRIES);
        ent     = IDX_W'(int'(word) - BUF_BASE_WORD);
        xfer_wr = reg_wr && aligned && (word == WORD_W'(XFER_WORD));

        req_tx  = clamp_cnt(reg_wdata[XFER_TX_LSB +: CNT_W]);
        req_tot = clamp_cnt(reg_wdata[XFER_TOT_LSB +: CNT_W]);
        if (req_tot < req_tx) begin
            req_tot = req_tx;
        end
        nxt = {1'b0, r_q.idx} + NUM_W'(1);

        // Software writes
        if (reg_wr && aligned) begin
            if (buf_hit) begin
                r_d.mem[ent] = reg_wdata[7:0];
            end else if (word == WORD_W'(CFG_WORD)) begin
                r_d.en    = reg_wdata[CFG_EN_BIT];
                r_d.cs_en = reg_wdata[CFG_CSEN_BIT];
                r_d.div   = reg_wdata[CFG_DIV_LSB +: DIV_W];
            end else if (word == WORD_W'(XFER_WORD) && r_q.st == ST_IDLE && r_q.en) begin
                r_d.tx_raw  = reg_wdata[XFER_TX_LSB +: CNT_W];
                r_d.tot_raw = reg_wdata[XFER_TOT_LSB +: CNT_W];
                if (req_tot != '0) begin
                    r_d.st   = ST_LEAD;
                    r_d.ntx  = req_tx;
                    r_d.ntot = req_tot;
                    r_d.idx  = '0;
                    r_d.bits = '0;
                    r_d.sck  = 1'b0;
                    shf_load = 1'b1;
                    shf_byte = (req_tx != '0) ? r_q.mem[0] : 8'h00;
                end
            end
        end

        // Serial engine (takes priority over software buffer writes)
        case (r_q.st)
            ST_LEAD: begin
                if (tick) begin
                    r_d.sck    = 1'b1;
                    shf_sample = 1'b1;
                    r_d.bits   = 4'd1;
                    r_d.st     = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (r_q.sck) begin
                        r_d.sck = 1'b0;
                        if (r_q.bits == 4'd8) begin
                            if ({1'b0, r_q.idx} >= r_q.ntx) begin
                                r_d.mem[r_q.idx] = rx_byte;
                            end
                            if (nxt == r_q.ntot) begin
                                r_d.st = ST_TRAIL;
                            end else begin
                                r_d.idx  = nxt[IDX_W-1:0];
                                r_d.bits = '0;
                                shf_load = 1'b1;
                                shf_byte = (nxt < r_q.ntx) ? r_q.mem[nxt[IDX_W-1:0]] : 8'h00;
                            end
                        end else begin
                            shf_shift = 1'b1;
                        end
                    end else begin
                        r_d.sck    = 1'b1;
                        shf_sample = 1'b1;
                        r_d.bits   = r_q.bits + 4'd1;
                    end
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: ;
        endcase

        // Registered read data
        r_d.rdata = '0;
        if (buf_hit) begin
            r_d.rdata[7:0] = r_q.mem[ent];
        end else if (aligned && word == WORD_W'(CFG_WORD)) begin
            r_d.rdata[CFG_EN_BIT]               = r_q.en;
            r_d.rdata[CFG_CSEN_BIT]             = r_q.cs_en;
            r_d.rdata[CFG_DIV_LSB +: DIV_W]     = r_q.div;
        end else if (aligned && word == WORD_W'(STS_WORD)) begin
            r_d.rdata[STS_BUSY_BIT]             = (r_q.st != ST_IDLE);
        end else if (aligned && word == WORD_W'(XFER_WORD)) begin
            r_d.rdata[XFER_TX_LSB +: CNT_W]     = r_q.tx_raw;
            r_d.rdata[XFER_TOT_LSB +: CNT_W]    = r_q.tot_raw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign reg_rdata = r_q.rdata;
    assign spi_sck   = r_q.sck;
    assign spi_cs_n  = !(r_q.cs_en && r_q.st != ST_IDLE);
    assign spi_mosi  = mosi_raw;

    // Zero counts never leave idle
    assert_zero_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && xfer_wr
         && reg_wdata[XFER_TX_LSB +: CNT_W] == '0
         && reg_wdata[XFER_TOT_LSB +: CNT_W] == '0) |=> (r_q.st == ST_IDLE));

    // Transfer writes during a transaction leave the stored counts alone
    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE && xfer_wr) |=>
        (r_q.tx_raw == $past(r_q.tx_raw) && r_q.tot_raw == $past(r_q.tot_raw)));

    // The byte index stays below the clamped total while running
    assert_idx_in_total_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |-> ({1'b0, r_q.idx} < r_q.ntot && r_q.ntot <= NUM_W'(NUM_ENTRIES)));

    // With the controller disabled, an idle engine stays idle
    assert_disabled_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.en && r_q.st == ST_IDLE) |=> (r_q.st == ST_IDLE));

    // Serial clock is low whenever no transaction is running
    assert_sck_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> !spi_sck);

    // Chip select does not toggle between byte times
    assert_cs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SHIFT && $past(r_q.st) == ST_SHIFT && $stable(r_q.cs_en))
        |-> $stable(spi_cs_n));

endmodule

// File: tb/sim_spi_buf_master.sv
`timescale 1ns/1ps
module sim_spi_buf_master;

    localparam int    N      = 16;
    localparam real   TCLK   = 8.0;
    localparam logic [7:0] A_CFG  = 8'h00;
    localparam logic [7:0] A_STS  = 8'h08;
    localparam logic [7:0] A_XFER = 8'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        sck, cs_n, mosi, miso;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q[$];
    logic [7:0] model[N];

    int         total_bits = 0;
    int         base_bits = 0;
    logic [7:0] mon_sh = '0;
    realtime    t_rise_prev = 0, t_rise_last = 0, t_fall_last = 0, t_csf = 0, t_csr = 0;
    int         cs_fall_cnt = 0;

    always #4 clk = ~clk;

    spi_buf_master u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .spi_sck   (sck),
        .spi_cs_n  (cs_n),
        .spi_mosi  (mosi),
        .spi_miso  (miso)
    );

    function automatic logic [7:0] pat(input int k);
        return 8'h5A ^ 8'(k * 19);
    endfunction

    function automatic logic slave_bit(input int pos);
        logic [7:0] b;
        b = pat(pos / 8);
        return b[7 - (pos % 8)];
    endfunction

    // Slave: bit for the current byte time, advanced after each rising edge
    assign miso = slave_bit(total_bits - base_bits);

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: assemble MOSI bytes and compare against the scoreboard queue
    always @(posedge sck) begin
        t_rise_prev = t_rise_last;
        t_rise_last = $realtime;
        mon_sh      = {mon_sh[6:0], mosi};
        total_bits  = total_bits + 1;
        if (total_bits % 8 == 0) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected mosi byte", {56'h0, mon_sh}, 64'h0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(mon_sh == e, "R3 mosi byte", {56'h0, mon_sh}, {56'h0, e});
            end
        end
    end

    always @(negedge sck) t_fall_last = $realtime;
    always @(negedge cs_n) begin
        t_csf = $realtime;
        cs_fall_cnt++;
    end
    always @(posedge cs_n) t_csr = $realtime;

    task automatic reg_write(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [63:0] d);
        @(negedge clk);
        reg_addr = a;
        reg_wr   = 1'b0;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [63:0] s;
        for (int i = 0; i < 5000; i++) begin
            reg_read(A_STS, s);
            if (s[0] == 1'b0) return;
        end
        check(1'b0, "R6 busy never cleared", 64'h1, 64'h0);
    endtask

    function automatic int eff(input int c);
        return (c > N) ? N : c;
    endfunction

    // Driver: push expected MOSI bytes, then write the transfer register
    task automatic start_xfer(input int tx, input int tot);
        int etx, etot;
        etx  = eff(tx);
        etot = eff(tot);
        if (etot < etx) etot = etx;
        for (int i = 0; i < etot; i++) begin
            exp_q.push_back((i < etx) ? model[i] : 8'h00);
        end
        base_bits = total_bits;
        reg_write(A_XFER, 64'((tot << 8) | tx));
    endtask

    task automatic update_model(input int tx, input int tot);
        for (int i = tx; i < tot; i++) model[i] = pat(i);
    endtask

    task automatic check_entry(input int i, input string req);
        logic [63:0] d;
        reg_read(8'(8'h80 + 8 * i), d);
        check(d == {56'h0, model[i]}, req, d, {56'h0, model[i]});
    endtask

    initial begin
        logic [63:0] d;
        int b0, c0;
        real per;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(cs_n == 1'b1, "R1 cs_n after reset", {63'h0, cs_n}, 64'h1);
        check(sck == 1'b0, "R1 sck after reset", {63'h0, sck}, 64'h0);
        reg_read(A_CFG, d);
        check(d == 64'h0, "R1 config after reset", d, 64'h0);
        reg_read(A_STS, d);
        check(d == 64'h0, "R1 status after reset", d, 64'h0);

        // R2 configuration and buffer access
        reg_write(A_CFG, 64'h0303);
        reg_read(A_CFG, d);
        check(d == 64'h0303, "R2 config readback", d, 64'h0303);
        for (int i = 0; i < N; i++) begin
            model[i] = 8'(8'h21 + i * 7);
            reg_write(8'(8'h80 + 8 * i), {56'hDEAD_BEEF_0000_00, model[i]});
        end
        check_entry(5, "R2 buffer readback upper bits zero");
        reg_write(8'h83, 64'hEE);
        check_entry(0, "R2 unaligned write ignored");

        // R3 R5 R6 write-only, three bytes
        b0 = total_bits;
        start_xfer(3, 3);
        reg_read(A_STS, d);
        check(d[0] == 1'b1, "R6 busy during transaction", d, 64'h1);
        wait_idle();
        check(total_bits - b0 == 24, "R3 write-only bit count", 64'(total_bits - b0), 64'd24);
        check(cs_n == 1'b1, "R6 cs_n released when busy clears", {63'h0, cs_n}, 64'h1);
        per = t_rise_last - t_rise_prev;
        check(per == 6.0 * TCLK, "R7 sck period divider 3", 64'(int'(per)), 64'(int'(6.0 * TCLK)));
        check(t_csr - t_fall_last == 3.0 * TCLK, "R8 cs trail", 64'(int'(t_csr - t_fall_last)), 64'd24);
        check_entry(0, "R5 entry 0 unchanged");
        check_entry(2, "R5 entry 2 unchanged");
        check_entry(3, "R5 entry 3 unchanged");

        // R4 read phase: send 2, total 6
        start_xfer(2, 6);
        wait_idle();
        update_model(2, 6);
        for (int i = 0; i < 7; i++) check_entry(i, "R4 buffer after read");

        // R9 zero counts
        b0 = total_bits;
        reg_write(A_XFER, 64'h0);
        reg_read(A_STS, d);
        check(d[0] == 1'b0, "R9 no busy on zero counts", d, 64'h0);
        check(total_bits == b0, "R9 no clocks on zero counts", 64'(total_bits - b0), 64'h0);

        // R12 controller disabled
        reg_write(A_CFG, 64'h0302);
        b0 = total_bits;
        c0 = cs_fall_cnt;
        reg_write(A_XFER, 64'h0101);
        repeat (20) @(negedge clk);
        reg_read(A_STS, d);
        check(d[0] == 1'b0, "R12 no busy when disabled", d, 64'h0);
        check(total_bits == b0 && sck == 1'b0, "R12 sck idle when disabled", 64'(total_bits - b0), 64'h0);
        check(cs_fall_cnt == c0 && cs_n == 1'b1, "R12 cs_n high when disabled", 64'(cs_fall_cnt - c0), 64'h0);
        reg_write(A_CFG, 64'h0303);

        // R11 transfer write during busy is ignored; R8 lead
        b0 = total_bits;
        start_xfer(1, 1);
        reg_write(A_XFER, 64'h0404);
        wait_idle();
        check(total_bits - b0 == 8, "R11 second write ignored", 64'(total_bits - b0), 64'd8);
        reg_read(A_XFER, d);
        check(d == 64'h0101, "R11 transfer readback", d, 64'h0101);
        check((t_rise_last - 7.0 * 6.0 * TCLK) - t_csf == 3.0 * TCLK, "R8 cs lead divider 3",
              64'(int'((t_rise_last - 42.0 * TCLK) - t_csf)), 64'd24);

        // R10 clamping
        b0 = total_bits;
        start_xfer(20, 20);
        wait_idle();
        check(total_bits - b0 == 128, "R10 counts clamp to 16", 64'(total_bits - b0), 64'd128);
        b0 = total_bits;
        start_xfer(2, 1);
        wait_idle();
        check(total_bits - b0 == 16, "R10 total raised to send count", 64'(total_bits - b0), 64'd16);
        check_entry(1, "R10 entry unchanged when total below send");

        // R8 chip-select enable clear
        reg_write(A_CFG, 64'h0301);
        c0 = cs_fall_cnt;
        b0 = total_bits;
        start_xfer(1, 1);
        wait_idle();
        check(cs_fall_cnt == c0, "R8 cs_n stays high when cs enable clear", 64'(cs_fall_cnt - c0), 64'h0);
        check(total_bits - b0 == 8, "R8 transaction runs without cs", 64'(total_bits - b0), 64'd8);

        // R7 R8 divider 0x7D
        reg_write(A_CFG, 64'h7D03);
        start_xfer(1, 1);
        wait_idle();
        per = t_rise_last - t_rise_prev;
        check(per == 250.0 * TCLK, "R7 sck period divider 0x7D", 64'(int'(per)), 64'd2000);
        check((t_rise_last - 7.0 * per) - t_csf == 125.0 * TCLK, "R8 cs lead divider 0x7D",
              64'(int'((t_rise_last - 7.0 * per) - t_csf)), 64'd1000);

        // R7 divider 0 acts as 1
        reg_write(A_CFG, 64'h0003);
        start_xfer(1, 1);
        wait_idle();
        per = t_rise_last - t_rise_prev;
        check(per == 2.0 * TCLK, "R7 sck period divider 0", 64'(int'(per)), 64'd16);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3 all expected bytes seen", 64'(exp_q.size()), 64'h0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(TCLK * 150000.0);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule